// File: doc/BRIEF.md
# Serial link reset sequencer

This block orders the reset release of a point-to-point source-synchronous link that has a transmit half and a receive half, and tells the rest of the chip when the link can carry traffic. It combines a power-on reset, a two-bit soft-reset word held in a configuration register, a transmit-startup-complete indication and a receive clock-lock indication. From these it produces one active-low reset for each half and a single ready flag.

Every reset source acts asynchronously. The receive clock comes from a recovered or PLL-derived source and may be missing, so no reset can be allowed to wait for it. Each reset is released through a synchroniser clocked by its own half's clock. The receive half waits for three things before it leaves reset: the transmit half must be out of reset and finished, the receive clock must be locked, and then a programmable settling interval must pass. The `link_active` output lets users wait for the link itself rather than guess a delay.

Top module: `link_rst_seq`

## Requirements
- R1: While `por_n` is low, `tx_rst_n`, `rx_rst_n` and `link_active` are low, with or without running clocks, and no software action is needed to bring the link up after `por_n` rises.
- R2: `soft_rst` bit 0 (transmit) high forces `tx_rst_n` low at once. Because the receive half waits on the transmit half, `rx_rst_n` also goes low.
- R3: `soft_rst` bit 1 (receive) high forces `rx_rst_n` low at once and leaves `tx_rst_n` high.
- R4: `soft_rst` = 2'b11 holds both halves in reset together.
- R5: After every transmit reset source clears, `tx_rst_n` rises on the 2nd rising edge of `tx_clk`.
- R6: `rx_rst_n` stays low while `tx_rst_n` is low or `tx_done` is low.
- R7: `rx_rst_n` stays low while `rx_lock` is low, and a loss of lock pulls it low at once, including on the cycle in which the release would otherwise have happened.
- R8: After every receive reset condition clears, `rx_rst_n` rises on rising edge number `LOCK_WAIT`+2 of `rx_clk` (the 10th with the default of 8).
- R9: `link_active` is high exactly when `tx_rst_n`, `rx_rst_n` and `rx_lock` are all high, and it falls without waiting for a clock edge.
- R10: A `por_n` pulse in the middle of operation drops every output at once, and the full sequence of R5 and R8 then repeats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| por_n | input | 1 | Power-on reset, active low, asynchronous, unregistered |
| tx_clk | input | 1 | Transmit half clock |
| rx_clk | input | 1 | Receive half clock, may be absent |
| soft_rst | input | 2 | Configuration soft reset; bit 0 transmit, bit 1 receive, 1 = hold in reset |
| tx_done | input | 1 | Transmit half has finished its startup and is stable |
| rx_lock | input | 1 | Receive clock is locked and running |
| tx_rst_n | output | 1 | Transmit half reset, active low |
| rx_rst_n | output | 1 | Receive half reset, active low |
| link_active | output | 1 | Link ready for traffic |

## Verification
Two events can fall on the same receive-clock edge: the settling counter reaching its final count, and a new reset cause such as a loss of lock. The bench clears every receive condition, counts nine `rx_clk` edges, drops `rx_lock` just before the tenth edge, and then requires `rx_reset_n` and `link_active` to stay low after that edge. A sweep over every combination of the soft-reset word, `tx_done` and `rx_lock` compares the settled outputs with values derived from R2, R3, R6, R7 and R9. Separate checks sample right after each asynchronous cause, before any clock edge can act.

// File: rtl/link_rst_pkg.sv
package link_rst_pkg;
  // Bit positions inside the configuration soft-reset word.
  localparam int SOFT_TX_BIT = 0;
  localparam int SOFT_RX_BIT = 1;
  localparam int SOFT_W      = 2;

  typedef struct packed {
    logic tx;
    logic rx;
  } rst_src_t;
endpackage

// File: rtl/link_rst_sync.sv
// Reset synchroniser: assertion is asynchronous, release is taken through STAGES flops.
module link_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/link_rx_settle.sv
// Counts WAIT_CYCLES clock cycles after 'start' before releasing the reset.
module link_rx_settle #(
  parameter int WAIT_CYCLES = 8
) (
  input  logic clk,
  input  logic arst_n,
  input  logic start,
  output logic rel_n
);
  localparam int CW = (WAIT_CYCLES < 2) ? 1 : $clog2(WAIT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WAIT_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start && !done_q;
    cnt_d  = cnt_q;
    done_d = done_q;
    if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign rel_n = done_q;
endmodule

// File: rtl/link_rst_seq.sv
module link_rst_seq
  import link_rst_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_WAIT   = 8
) (
  input  logic              por_n,
  input  logic              tx_clk,
  input  logic              rx_clk,
  input  logic [SOFT_W-1:0] soft_rst,
  input  logic              tx_done,
  input  logic              rx_lock,
  output logic              tx_rst_n,
  output logic              rx_rst_n,
  output logic              link_active
);
  rst_src_t hold;
  logic     tx_arst_n;
  logic     rx_arst_n;
  logic     rx_start;

  // Any reset cause is combinational so that it acts without a clock.
  always_comb begin
    hold.tx   = !por_n || soft_rst[SOFT_TX_BIT];
    hold.rx   = !por_n || soft_rst[SOFT_RX_BIT] || !tx_rst_n || !tx_done || !rx_lock;
    tx_arst_n = !hold.tx;
    rx_arst_n = !hold.rx;
  end

  link_rst_sync #(.STAGES(SYNC_STAGES)) u_tx_sync (
    .clk    (tx_clk),
    .arst_n (tx_arst_n),
    .rst_n  (tx_rst_n)
  );

  link_rst_sync #(.STAGES(SYNC_STAGES)) u_rx_sync (
    .clk    (rx_clk),
    .arst_n (rx_arst_n),
    .rst_n  (rx_start)
  );

  link_rx_settle #(.WAIT_CYCLES(LOCK_WAIT)) u_rx_settle (
    .clk    (rx_clk),
    .arst_n (rx_arst_n),
    .start  (rx_start),
    .rel_n  (rx_rst_n)
  );

  assign link_active = tx_rst_n && rx_rst_n && rx_lock;
endmodule

// File: rtl/link_rst_chk.sv
module link_rst_chk (
  input logic       por_n,
  input logic       tx_clk,
  input logic       rx_clk,
  input logic [1:0] soft_rst,
  input logic       tx_done,
  input logic       rx_lock,
  input logic       tx_rst_n,
  input logic       rx_rst_n,
  input logic       link_active
);
  p_soft_tx_r2: assert property (@(posedge tx_clk) disable iff (!por_n)
    soft_rst[0] |-> !tx_rst_n);

  p_soft_rx_r3: assert property (@(posedge rx_clk) disable iff (!por_n)
    soft_rst[1] |-> (!rx_rst_n && !link_active));

  p_rx_after_tx_r6: assert property (@(posedge rx_clk) disable iff (!por_n)
    rx_rst_n |-> (tx_rst_n && tx_done));

  p_lock_hold_r7: assert property (@(posedge rx_clk) disable iff (!por_n)
    !rx_lock |-> (!rx_rst_n && !link_active));

  p_release_cause_r8: assert property (@(posedge rx_clk) disable iff (!por_n)
    $rose(rx_rst_n) |-> ($past(rx_lock) && $past(tx_rst_n)));
endmodule

bind link_rst_seq link_rst_chk u_chk (
  .por_n       (por_n),
  .tx_clk      (tx_clk),
  .rx_clk      (rx_clk),
  .soft_rst    (soft_rst),
  .tx_done     (tx_done),
  .rx_lock     (rx_lock),
  .tx_rst_n    (tx_rst_n),
  .rx_rst_n    (rx_rst_n),
  .link_active (link_active)
);

// File: tb/sim_link_rst_seq.sv
`timescale 1ns/1ps
module sim_link_rst_seq;
  localparam int WAIT = 8;
  localparam int RXN  = WAIT + 2;

  logic       run;
  logic       tx_clk, rx_clk;
  logic       por_n;
  logic [1:0] soft_rst;
  logic       tx_done, rx_lock;
  logic       tx_rst_n, rx_rst_n, link_active;
  int         n_chk, n_err;

  link_rst_seq #(.SYNC_STAGES(2), .LOCK_WAIT(WAIT)) u0 (
    .por_n(por_n), .tx_clk(tx_clk), .rx_clk(rx_clk), .soft_rst(soft_rst),
    .tx_done(tx_done), .rx_lock(rx_lock), .tx_rst_n(tx_rst_n),
    .rx_rst_n(rx_rst_n), .link_active(link_active)
  );

  initial begin
    tx_clk = 1'b0;
    forever #5 tx_clk = run ? ~tx_clk : tx_clk;
  end
  initial begin
    rx_clk = 1'b0;
    #3;
    forever #5 rx_clk = run ? ~rx_clk : rx_clk;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic all_low(input string req);
    chk({req, " tx_rst_n"}, tx_rst_n, 1'b0);
    chk({req, " rx_rst_n"}, rx_rst_n, 1'b0);
    chk({req, " link_active"}, link_active, 1'b0);
  endtask

  // Receive release count: the rx conditions clear just after an rx falling edge.
  task automatic rx_count(input string req);
    for (int k = 1; k <= RXN; k++) begin
      @(posedge rx_clk); #1;
      chk(req, rx_rst_n, (k >= RXN));
    end
    chk({req, " R9 active"}, link_active, 1'b1);
  endtask

  task automatic tx_count(input string req);
    for (int k = 1; k <= 2; k++) begin
      @(posedge tx_clk); #1;
      chk(req, tx_rst_n, (k >= 2));
    end
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0;
    run = 1'b1; por_n = 1'b0; soft_rst = 2'b00; tx_done = 1'b0; rx_lock = 1'b0;
    #1 all_low("R1 reset state");
    repeat (4) @(posedge tx_clk);
    #2 all_low("R1 held");

    // Power-on release: tx first (R5), rx waits on tx_done (R6).
    @(negedge tx_clk) por_n = 1'b1;
    tx_count("R5 tx release");
    chk("R6 rx held before tx_done", rx_rst_n, 1'b0);
    @(negedge rx_clk) rx_lock = 1'b1;
    repeat (20) @(negedge rx_clk);
    chk("R6 rx held without tx_done", rx_rst_n, 1'b0);
    tx_done = 1'b1;
    rx_count("R8 rx release");

    // Lock loss acts without a clock edge.
    @(posedge rx_clk) #2 rx_lock = 1'b0;
    #1 chk("R7 lock loss rx", rx_rst_n, 1'b0);
    chk("R9 lock loss active", link_active, 1'b0);
    chk("R7 lock loss leaves tx", tx_rst_n, 1'b1);

    // Lock lost on the very edge the release would land.
    @(negedge rx_clk) rx_lock = 1'b1;
    for (int k = 1; k < RXN; k++) @(posedge rx_clk);
    #1 chk("R8 still low before last edge", rx_rst_n, 1'b0);
    rx_lock = 1'b0;
    @(posedge rx_clk); #1;
    chk("R7 coincident lock loss rx", rx_rst_n, 1'b0);
    chk("R7 coincident lock loss active", link_active, 1'b0);
    @(negedge rx_clk) rx_lock = 1'b1;
    rx_count("R8 release after relock");

    // Soft reset bits on their own and together.
    @(posedge tx_clk) #2 soft_rst = 2'b10;
    #1 chk("R3 rx soft rx_rst_n", rx_rst_n, 1'b0);
    repeat (6) @(negedge tx_clk);
    chk("R3 rx soft leaves tx", tx_rst_n, 1'b1);
    chk("R3 rx soft active", link_active, 1'b0);
    @(negedge rx_clk) soft_rst = 2'b00;
    rx_count("R8 release after rx soft");

    @(posedge tx_clk) #2 soft_rst = 2'b01;
    #1 chk("R2 tx soft tx_rst_n", tx_rst_n, 1'b0);
    chk("R2 tx soft rx_rst_n", rx_rst_n, 1'b0);
    chk("R2 tx soft active", link_active, 1'b0);
    @(negedge tx_clk) soft_rst = 2'b00;
    tx_count("R5 release after tx soft");
    repeat (RXN + 2) @(negedge rx_clk);
    chk("R9 active after tx soft", link_active, 1'b1);

    @(posedge rx_clk) #2 soft_rst = 2'b11;
    #1 all_low("R4 both soft");
    repeat (6) @(negedge tx_clk);
    all_low("R4 both soft held");

    // Sweep every soft/tx_done/rx_lock combination and judge settled outputs.
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 2; d++) begin
        for (int l = 0; l < 2; l++) begin
          logic e_tx, e_rx;
          @(negedge tx_clk);
          soft_rst = 2'(s); tx_done = d[0]; rx_lock = l[0];
          repeat (20) @(negedge tx_clk);
          e_tx = !s[0];
          e_rx = e_tx && !s[1] && d[0] && l[0];
          chk("R2 sweep tx_rst_n", tx_rst_n, e_tx);
          chk("R6 sweep rx_rst_n", rx_rst_n, e_rx);
          chk("R9 sweep link_active", link_active, e_rx);
        end
      end
    end

    // Mid-operation power-on reset and full recovery.
    @(negedge tx_clk) soft_rst = 2'b00;
    repeat (20) @(negedge tx_clk);
    chk("R10 active before pulse", link_active, 1'b1);
    #3 por_n = 1'b0;
    #1 all_low("R10 mid por");
    tx_done = 1'b0;
    repeat (3) @(negedge tx_clk);
    por_n = 1'b1;
    tx_count("R10 tx release");
    chk("R10 rx held", rx_rst_n, 1'b0);
    @(negedge rx_clk) tx_done = 1'b1;
    rx_count("R10 rx release");

    // Reset with no clocks at all.
    run = 1'b0;
    #20 por_n = 1'b0;
    #1 all_low("R1 no clock");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule